// File: doc/BRIEF.md
# Execute-Stage ALU with Selective Condition Codes

This block is the arithmetic and logic unit of a pipeline's execute stage. It takes two 32-bit operands and a 4-bit operation select, and it registers the result on the next rising clock edge. Next to the result it keeps a 4-bit condition code register that holds three flags: zero, negative and carry.

Each flag is updated only by the operation classes that define it. Arithmetic operations write all three flags. Shift operations also write all three, except that a shift by zero leaves carry alone. Logical operations write only zero and negative. Moves and every other operation leave the flags as they are. Flags change only while the write-flags enable is high.

After an interrupt, a restore input loads a saved flag value straight into the register. The restore wins over any flag update requested in the same cycle.

Top module: `exec_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `ccr` both become 0 after that edge.
- R2: `result` shows, one clock after the inputs are sampled, the value for `op_sel`. The codes are: 0 pass A, 1 pass B, 2 A+B, 3 A-B, 4 A+1, 5 A-1, 6 A AND B, 7 A OR B, 8 A XOR B, 9 NOT A, 10 shift A left by B[4:0], 11 logical shift A right by B[4:0]. Codes 12 to 15 give 0.
- R3: For the arithmetic codes (2 to 5), the logical codes (6 to 9) and the shift codes (10, 11), with `flag_we` high and no restore, `ccr` bit 0 is set exactly when the new result is zero, and `ccr` bit 1 equals bit 31 of the new result.
- R4: For add (2) and increment (4), `ccr` bit 2 becomes the carry out of bit 31. For subtract (3) and decrement (5), it becomes the borrow, which is 1 when the subtrahend is greater than A as unsigned values.
- R5: For a shift by a nonzero amount, `ccr` bit 2 becomes the last bit shifted out. For shift left by n this is A[32-n]; for shift right by n it is A[n-1]. A shift by zero leaves bit 2 unchanged.
- R6: The logical codes (6 to 9) leave `ccr` bit 2 unchanged.
- R7: The pass codes (0, 1) and the codes 12 to 15 leave all of `ccr` unchanged.
- R8: With `flag_we` low and no restore, `ccr` does not change.
- R9: With `ccr_restore_en` high, `ccr` becomes `ccr_restore_val` with bit 3 cleared on the next edge, whatever `flag_we` and `op_sel` are.
- R10: `ccr` bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opd_a | input | 32 | Operand A |
| opd_b | input | 32 | Operand B (low 5 bits give the shift amount) |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Enables the flag update for this operation |
| ccr_restore_en | input | 1 | Loads the flags from `ccr_restore_val` |
| ccr_restore_val | input | 4 | Saved flag value to restore |
| result | output | 32 | Registered result |
| ccr | output | 4 | Condition codes: bit 0 zero, bit 1 negative, bit 2 carry, bit 3 zero |

## Verification
The assertions assume that every control input holds a known 0 or 1 value at each rising edge. They also assume that the inputs are stable around that edge, so the value the checker samples is the one the flag logic uses. The stimulus changes inputs only on falling edges and never drives X. It covers all sixteen operation codes, including the unused ones, and gives `ccr_restore_val` bit 3 set as often as clear, so the bit 3 checks hold for any restore value.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int CCR_W = 4;
  localparam int ZF_BIT = 0;
  localparam int NF_BIT = 1;
  localparam int CF_BIT = 2;

  typedef enum logic [3:0] {
    OP_PASS_A = 4'd0,
    OP_PASS_B = 4'd1,
    OP_ADD    = 4'd2,
    OP_SUB    = 4'd3,
    OP_INC    = 4'd4,
    OP_DEC    = 4'd5,
    OP_AND    = 4'd6,
    OP_OR     = 4'd7,
    OP_XOR    = 4'd8,
    OP_NOT    = 4'd9,
    OP_SHL    = 4'd10,
    OP_SHR    = 4'd11,
    OP_RSV12  = 4'd12,
    OP_RSV13  = 4'd13,
    OP_RSV14  = 4'd14,
    OP_RSV15  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_LOGIC = 2'd2,
    CLS_SHIFT = 2'd3
  } op_class_e;

  function automatic op_class_e op_class(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: op_class = CLS_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT:  op_class = CLS_LOGIC;
      OP_SHL, OP_SHR:                 op_class = CLS_SHIFT;
      default:                        op_class = CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] sum,
  output logic              carry
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] b_eff;
  logic              is_sub;
  logic [DATA_W:0]   wide;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_DEC);
    b_eff  = ((op == OP_INC) || (op == OP_DEC)) ? ONE : b;
    if (is_sub) begin
      wide  = {1'b0, a} + {1'b0, ~b_eff} + {{DATA_W{1'b0}}, 1'b1};
      carry = ~wide[DATA_W];
    end else begin
      wide  = {1'b0, a} + {1'b0, b_eff};
      carry = wide[DATA_W];
    end
    sum = wide[DATA_W-1:0];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               left,
  output logic [DATA_W-1:0]  y,
  output logic               carry
);
  logic [DATA_W:0] left_w;
  logic [DATA_W:0] right_w;

  always_comb begin
    left_w  = {1'b0, a} << shamt;
    right_w = {a, 1'b0} >> shamt;
    if (left) begin
      y     = left_w[DATA_W-1:0];
      carry = left_w[DATA_W];
    end else begin
      y     = right_w[DATA_W:1];
      carry = right_w[0];
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_zn,
  input  logic             upd_c,
  input  logic             z_new,
  input  logic             n_new,
  input  logic             c_new,
  input  logic             restore_en,
  input  logic [CCR_W-1:0] restore_val,
  output logic [CCR_W-1:0] ccr_q
);
  logic [CCR_W-1:0] ccr_d;

  always_comb begin
    ccr_d = ccr_q;
    if (restore_en) begin
      ccr_d = restore_val & 4'b0111;
    end else begin
      if (upd_zn) begin
        ccr_d[ZF_BIT] = z_new;
        ccr_d[NF_BIT] = n_new;
      end
      if (upd_c) ccr_d[CF_BIT] = c_new;
    end
    ccr_d[3] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ccr_q <= '0;
    else     ccr_q <= ccr_d;
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opd_a,
  input  logic [DATA_W-1:0] opd_b,
  input  logic [3:0]        op_sel,
  input  logic              flag_we,
  input  logic              ccr_restore_en,
  input  logic [3:0]        ccr_restore_val,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccr
);
  alu_op_e           op;
  op_class_e         cls;
  logic [DATA_W-1:0] arith_y, logic_y, shift_y, res_d;
  logic              arith_c, shift_c, c_sel;
  logic              shamt_nz;

  assign op       = alu_op_e'(op_sel);
  assign cls      = op_class(op);
  assign shamt_nz = |opd_b[SHAMT_W-1:0];

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(opd_a), .b(opd_b), .op(op), .sum(arith_y), .carry(arith_c)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(opd_a), .b(opd_b), .op(op), .y(logic_y)
  );

  alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .a(opd_a), .shamt(opd_b[SHAMT_W-1:0]), .left(op == OP_SHL),
    .y(shift_y), .carry(shift_c)
  );

  always_comb begin
    case (op)
      OP_PASS_A: res_d = opd_a;
      OP_PASS_B: res_d = opd_b;
      default: begin
        case (cls)
          CLS_ARITH: res_d = arith_y;
          CLS_LOGIC: res_d = logic_y;
          CLS_SHIFT: res_d = shift_y;
          default:   res_d = '0;
        endcase
      end
    endcase
    c_sel = (cls == CLS_SHIFT) ? shift_c : arith_c;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= res_d;
  end

  alu_flags u_flags (
    .clk(clk),
    .rst(rst),
    .upd_zn(flag_we && (cls != CLS_NONE)),
    .upd_c(flag_we && ((cls == CLS_ARITH) || ((cls == CLS_SHIFT) && shamt_nz))),
    .z_new(res_d == '0),
    .n_new(res_d[DATA_W-1]),
    .c_new(c_sel),
    .restore_en(ccr_restore_en),
    .restore_val(ccr_restore_val),
    .ccr_q(ccr)
  );
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_sel,
  input logic              flag_we,
  input logic              ccr_restore_en,
  input logic [3:0]        ccr_restore_val,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        ccr
);
  logic is_logic, is_flagged, is_quiet;
  assign is_logic   = (op_sel >= 4'd6) && (op_sel <= 4'd9);
  assign is_flagged = (op_sel >= 4'd2) && (op_sel <= 4'd11);
  assign is_quiet   = !is_flagged;

  // R10
  reserved_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ccr[3] == 1'b0);

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_we && !ccr_restore_en) |=> $stable(ccr));

  // R9
  restore_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ccr_restore_en |=> (ccr == ($past(ccr_restore_val) & 4'b0111)));

  // R7
  quiet_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (is_quiet && !ccr_restore_en) |=> $stable(ccr));

  // R6
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (is_logic && !ccr_restore_en) |=> $stable(ccr[2]));

  // R3
  zn_track_chk: assert property (@(posedge clk) disable iff (rst)
    (is_flagged && flag_we && !ccr_restore_en) |=>
      ((ccr[0] == (result == '0)) && (ccr[1] == result[DATA_W-1])));
endmodule

bind exec_alu alu_chk #(.DATA_W(DATA_W)) i_alu_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .flag_we(flag_we),
  .ccr_restore_en(ccr_restore_en), .ccr_restore_val(ccr_restore_val),
  .result(result), .ccr(ccr)
);

// File: tb/test_exec_alu.sv
`timescale 1ns/1ps
module test_exec_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opd_a, opd_b;
  logic [3:0]  op_sel;
  logic        flag_we, ccr_restore_en;
  logic [3:0]  ccr_restore_val;
  logic [31:0] result;
  logic [3:0]  ccr;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_res = '0;
  logic [3:0]  exp_ccr = '0;

  always #2 clk = ~clk;

  exec_alu i_exec_alu (
    .clk(clk), .rst(rst), .opd_a(opd_a), .opd_b(opd_b), .op_sel(op_sel),
    .flag_we(flag_we), .ccr_restore_en(ccr_restore_en),
    .ccr_restore_val(ccr_restore_val), .result(result), .ccr(ccr)
  );

  // Behavioural reference: advances exp_res / exp_ccr by one clock.
  task automatic model(input logic r, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] op, input logic we, input logic rs,
                       input logic [3:0] rv);
    longint unsigned t;
    logic [31:0] y;
    logic c;
    logic set_zn, set_c;
    int n;
    y = 0; c = 0; set_zn = 0; set_c = 0;
    case (op)
      0: y = a;
      1: y = b;
      2: begin t = longint'(a) + longint'(b); y = t[31:0]; c = t[32]; set_zn = 1; set_c = 1; end
      3: begin y = a - b; c = (b > a); set_zn = 1; set_c = 1; end
      4: begin y = a + 1; c = (a == 32'hFFFF_FFFF); set_zn = 1; set_c = 1; end
      5: begin y = a - 1; c = (a == 0); set_zn = 1; set_c = 1; end
      6: begin y = a & b; set_zn = 1; end
      7: begin y = a | b; set_zn = 1; end
      8: begin y = a ^ b; set_zn = 1; end
      9: begin y = ~a; set_zn = 1; end
      10, 11: begin
        n = int'(b[4:0]);
        y = a;
        for (int i = 0; i < n; i++) begin
          if (op == 10) begin c = y[31]; y = y << 1; end
          else          begin c = y[0];  y = y >> 1; end
        end
        set_zn = 1; set_c = (n != 0);
      end
      default: y = 0;
    endcase
    if (r) begin
      exp_res = 0; exp_ccr = 0;
    end else begin
      exp_res = y;
      if (rs) exp_ccr = {1'b0, rv[2:0]};
      else if (we) begin
        if (set_zn) begin exp_ccr[0] = (y == 0); exp_ccr[1] = y[31]; end
        if (set_c) exp_ccr[2] = c;
      end
    end
  endtask

  // Called at a falling edge; compares after the next rising edge.
  task automatic step(input string tag, input logic r, input logic [31:0] a,
                      input logic [31:0] b, input logic [3:0] op, input logic we,
                      input logic rs, input logic [3:0] rv);
    rst = r; opd_a = a; opd_b = b; op_sel = op; flag_we = we;
    ccr_restore_en = rs; ccr_restore_val = rv;
    model(r, a, b, op, we, rs, rv);
    @(posedge clk);
    #1;
    vectors++;
    if (result !== exp_res || ccr !== exp_ccr) begin
      miscompares++;
      $display("FAIL %s op=%0d: result=%h ccr=%b expected result=%h ccr=%b",
               tag, op, result, ccr, exp_res, exp_ccr);
    end
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic rs, input logic we);
    if (rs) return "R9";
    if (!we) return "R8";
    if (op <= 1 || op >= 12) return "R7";
    if (op >= 6 && op <= 9) return "R6";
    if (op >= 10) return "R5";
    return "R4";
  endfunction

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1; opd_a = 0; opd_b = 0; op_sel = 0; flag_we = 0;
    ccr_restore_en = 0; ccr_restore_val = 0;
    @(negedge clk);
    // R1 reset state
    step("R1", 1, 32'h1234, 32'h5678, 4'd2, 1, 0, 0);
    step("R1", 1, 32'hFFFF_FFFF, 32'h1, 4'd2, 1, 0, 0);
    // R2 results for each code
    for (int k = 0; k < 16; k++)
      step("R2", 0, 32'hA5A5_0F0F, 32'h0000_0003, 4'(k), 0, 0, 0);
    // R3 zero and negative
    step("R3", 0, 32'h5, 32'h5, 4'd3, 1, 0, 0);
    step("R3", 0, 32'h8000_0000, 32'h0, 4'd7, 1, 0, 0);
    // R4 carry and borrow edges
    step("R4", 0, 32'hFFFF_FFFF, 32'h1, 4'd2, 1, 0, 0);
    step("R4", 0, 32'h0, 32'h1, 4'd3, 1, 0, 0);
    step("R4", 0, 32'hFFFF_FFFF, 32'h0, 4'd4, 1, 0, 0);
    step("R4", 0, 32'h0, 32'h0, 4'd5, 1, 0, 0);
    step("R4", 0, 32'h7, 32'h3, 4'd3, 1, 0, 0);
    // R5 shifts
    step("R5", 0, 32'h8000_0001, 32'd1, 4'd10, 1, 0, 0);
    step("R5", 0, 32'h0000_0002, 32'd0, 4'd11, 1, 0, 0);
    step("R5", 0, 32'h0000_0001, 32'd31, 4'd10, 1, 0, 0);
    step("R5", 0, 32'h4000_0000, 32'd31, 4'd11, 1, 0, 0);
    step("R5", 0, 32'h0000_0001, 32'd1, 4'd11, 1, 0, 0);
    // R6 logical ops keep carry (carry is now set)
    step("R6", 0, 32'h0, 32'h0, 4'd6, 1, 0, 0);
    step("R6", 0, 32'hFFFF_FFFF, 32'h0, 4'd9, 1, 0, 0);
    // R7 quiet codes
    step("R7", 0, 32'h0, 32'h0, 4'd0, 1, 0, 0);
    step("R7", 0, 32'h8000_0000, 32'h8000_0000, 4'd1, 1, 0, 0);
    step("R7", 0, 32'h0, 32'h0, 4'd13, 1, 0, 0);
    // R8 no enable
    step("R8", 0, 32'h0, 32'h0, 4'd2, 0, 0, 0);
    // R9 restore beats update; R10 bit 3 cleared
    step("R9", 0, 32'h0, 32'h0, 4'd2, 1, 1, 4'b0110);
    step("R10", 0, 32'h0, 32'h0, 4'd0, 0, 1, 4'b1111);
    step("R10", 0, 32'hFFFF_FFFF, 32'h1, 4'd2, 1, 0, 0);
    // random mix
    for (int k = 0; k < 2000; k++) begin
      logic [3:0] op;
      logic we, rs;
      op = 4'($urandom_range(0, 15));
      we = ($urandom_range(0, 3) != 0);
      rs = ($urandom_range(0, 9) == 0);
      step(tag_of(op, rs, we), 0, $urandom(), ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 31)) : $urandom(),
           op, we, rs, 4'($urandom_range(0, 15)));
    end
    step("R1", 1, 32'h1, 32'h1, 4'd2, 1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule